// File: doc/BRIEF.md
# Register-Busy Issue Interlock

This block sits in the issue stage of a processor with several functional units that run in parallel and take different numbers of cycles. It holds one busy flag per accumulator register and one busy flag per functional unit. When an instruction is accepted for a unit, that unit and the instruction's destination register are marked busy. They stay busy until the unit raises its completion pulse.

Each cycle the block checks the offered instruction against the flags. An instruction that reads or writes a register still owned by an unfinished unit is held, and so is one aimed at a unit that is still working. The stall output stays high until the conflict clears. Instructions that touch only free registers and go to a free unit are accepted at once, even while a long operation such as a divide is still running elsewhere.

A completion pulse takes effect in the same cycle it arrives. An instruction that was waiting only on that unit is therefore accepted in that cycle, and the new owner's mark replaces the old one.

Top module: `issueInterlock`

## Requirements
- R1: While reset is low, and on the first cycle after it, every register busy flag and every unit busy flag reads 0.
- R2: An accepted issue (issueValid high, stall low) makes `regBusy[issueDst]` and `unitBusy[issueUnit]` read 1 on the next cycle. Register and unit numbers are plain binary indices.
- R3: An offered issue whose `issueSrcA` or `issueSrcB` names a register that is busy and not being released this cycle raises stall.
- R4: An offered issue whose `issueDst` names a register that is busy and not being released this cycle raises stall.
- R5: An offered issue aimed at a unit that is busy and not completing this cycle raises stall.
- R6: An offered issue with no conflict of the kinds in R3 to R5 is accepted (stall low), whatever other units are still in flight.
- R7: Bit k of `doneValid` is the completion pulse of unit k. A pulse from a busy unit clears that unit's flag and the flag of the register it owns on the next cycle, unless the same cycle's accepted issue sets them again.
- R8: When a completion and an accepted issue name the same register in one cycle, the completion is applied first. The issue is therefore accepted, and the register reads busy on the next cycle, now owned by the issuing unit.
- R9: A completion pulse from a unit whose busy flag is 0 changes no flag.
- R10: Stall is 0 whenever issueValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is offered this cycle |
| issueUnit | input | UNIT_W | Target functional unit index |
| issueDst | input | REG_W | Destination register index |
| issueSrcA | input | REG_W | First source register index |
| issueSrcB | input | REG_W | Second source register index |
| doneValid | input | NUM_UNITS | Completion pulse, one bit per unit |
| stall | output | 1 | Offered instruction is held this cycle |
| regBusy | output | NUM_REGS | Busy flag per register |
| unitBusy | output | NUM_UNITS | Busy flag per unit |

## Verification
The bench builds the block with its default configuration of eight registers and four units. With three register references per instruction and only four units, random traffic often runs into every kind of conflict: source hits, destination hits and busy units. Because completion pulses are sparse, several units stay in flight together. Random pulses also land on idle units and, at times, on the same register that a new issue names in the same cycle. That brings same-cycle release and unblocking into reach alongside the directed cases.

// File: rtl/ilkPkg.sv
package ilkPkg;
  parameter int NUM_REGS  = 8;
  parameter int NUM_UNITS = 4;
  localparam int REG_W  = $clog2(NUM_REGS);
  localparam int UNIT_W = $clog2(NUM_UNITS);

  // strobes from control to datapath
  typedef struct packed {
    logic                 accept;
    logic [NUM_UNITS-1:0] retire;
    logic [NUM_REGS-1:0]  clearMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/ilkControl.sv
module ilkControl
  import ilkPkg::*;
(
  input  logic                       issueValid,
  input  logic [UNIT_W-1:0]          issueUnit,
  input  logic [REG_W-1:0]           issueDst,
  input  logic [REG_W-1:0]           issueSrcA,
  input  logic [REG_W-1:0]           issueSrcB,
  input  logic [NUM_UNITS-1:0]       doneValid,
  input  logic [NUM_REGS-1:0]        regBusy,
  input  logic [NUM_UNITS-1:0]       unitBusy,
  input  logic [NUM_UNITS*REG_W-1:0] ownerFlat,
  output ctrlStrobes_t               strobes,
  output logic                       stall
);
  logic [NUM_REGS-1:0]  effReg;
  logic [NUM_UNITS-1:0] effUnit;
  logic                 conflict;

  always_comb begin
    strobes.retire    = doneValid & unitBusy;
    strobes.clearMask = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (strobes.retire[u])
        strobes.clearMask[ownerFlat[u*REG_W +: REG_W]] = 1'b1;
    end
    // release first, then test the offered instruction
    effReg   = regBusy & ~strobes.clearMask;
    effUnit  = unitBusy & ~strobes.retire;
    conflict = effReg[issueDst] | effReg[issueSrcA] | effReg[issueSrcB] |
               effUnit[issueUnit];
    stall          = issueValid & conflict;
    strobes.accept = issueValid & ~conflict;
  end
endmodule

// File: rtl/ilkDatapath.sv
module ilkDatapath
  import ilkPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [UNIT_W-1:0]          issueUnit,
  input  logic [REG_W-1:0]           issueDst,
  output logic [NUM_REGS-1:0]        regBusy,
  output logic [NUM_UNITS-1:0]       unitBusy,
  output logic [NUM_UNITS*REG_W-1:0] ownerFlat
);
  logic [NUM_REGS-1:0] setMask;

  assign setMask = strobes.accept ? (NUM_REGS'(1) << issueDst) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) regBusy <= '0;
    else       regBusy <= (regBusy & ~strobes.clearMask) | setMask;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic take;
    assign take = strobes.accept && (issueUnit == UNIT_W'(u));

    always_ff @(posedge clk) begin
      if (!rstN)                  unitBusy[u] <= 1'b0;
      else if (take)              unitBusy[u] <= 1'b1;
      else if (strobes.retire[u]) unitBusy[u] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)     ownerFlat[u*REG_W +: REG_W] <= '0;
      else if (take) ownerFlat[u*REG_W +: REG_W] <= issueDst;
    end
  end
endmodule

// File: rtl/issueInterlock.sv
module issueInterlock
  import ilkPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [UNIT_W-1:0]    issueUnit,
  input  logic [REG_W-1:0]     issueDst,
  input  logic [REG_W-1:0]     issueSrcA,
  input  logic [REG_W-1:0]     issueSrcB,
  input  logic [NUM_UNITS-1:0] doneValid,
  output logic                 stall,
  output logic [NUM_REGS-1:0]  regBusy,
  output logic [NUM_UNITS-1:0] unitBusy
);
  ctrlStrobes_t               strobes;
  logic [NUM_UNITS*REG_W-1:0] ownerFlat;

  ilkControl u_ctrl (
    .issueValid(issueValid), .issueUnit(issueUnit), .issueDst(issueDst),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .doneValid(doneValid),
    .regBusy(regBusy), .unitBusy(unitBusy), .ownerFlat(ownerFlat),
    .strobes(strobes), .stall(stall)
  );

  ilkDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .issueUnit(issueUnit),
    .issueDst(issueDst), .regBusy(regBusy), .unitBusy(unitBusy),
    .ownerFlat(ownerFlat)
  );
endmodule

// File: rtl/issueInterlockChecker.sv
module issueInterlockChecker
  import ilkPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueValid,
  input logic [UNIT_W-1:0]    issueUnit,
  input logic [REG_W-1:0]     issueDst,
  input logic [REG_W-1:0]     issueSrcA,
  input logic [REG_W-1:0]     issueSrcB,
  input logic [NUM_UNITS-1:0] doneValid,
  input logic                 stall,
  input logic [NUM_REGS-1:0]  regBusy,
  input logic [NUM_UNITS-1:0] unitBusy
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (regBusy == '0 && unitBusy == '0));

  assert_set_on_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !stall) |=> (regBusy[$past(issueDst)] && unitBusy[$past(issueUnit)]));

  assert_src_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && doneValid == '0 && (regBusy[issueSrcA] || regBusy[issueSrcB])) |-> stall);

  assert_dst_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && doneValid == '0 && regBusy[issueDst]) |-> stall);

  assert_unit_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && doneValid == '0 && unitBusy[issueUnit]) |-> stall);

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_done
    assert_unit_release_R7: assert property (@(posedge clk) disable iff (!rstN)
      (doneValid[k] && unitBusy[k] && !(issueValid && !stall && issueUnit == UNIT_W'(k)))
      |=> !unitBusy[k]);
  end

  assert_idle_stall_R10: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> !stall);
endmodule

bind issueInterlock issueInterlockChecker u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
  .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
  .doneValid(doneValid), .stall(stall), .regBusy(regBusy), .unitBusy(unitBusy)
);

// File: tb/issueInterlock_tb.sv
module issueInterlock_tb;
  import ilkPkg::*;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 issueValid = 1'b0;
  logic [UNIT_W-1:0]    issueUnit = '0;
  logic [REG_W-1:0]     issueDst = '0, issueSrcA = '0, issueSrcB = '0;
  logic [NUM_UNITS-1:0] doneValid = '0;
  logic                 stall;
  logic [NUM_REGS-1:0]  regBusy;
  logic [NUM_UNITS-1:0] unitBusy;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference state
  bit [NUM_REGS-1:0]  mReg;
  bit [NUM_UNITS-1:0] mUnit;
  int                 mOwner [NUM_UNITS];
  string              flagTag = "R1";

  always #10 clk = ~clk;

  issueInterlock u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .doneValid(doneValid), .stall(stall), .regBusy(regBusy), .unitBusy(unitBusy)
  );

  function automatic bit [NUM_REGS-1:0] relMask(input bit [NUM_UNITS-1:0] dn);
    bit [NUM_REGS-1:0] m = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (dn[u] && mUnit[u]) m[mOwner[u]] = 1'b1;
    return m;
  endfunction

  // expected stall and the requirement that decides it
  function automatic bit expStall(input bit v, input int u, input int d, input int a,
                                  input int b, input bit [NUM_UNITS-1:0] dn,
                                  output string tag);
    bit [NUM_REGS-1:0]  er = mReg & ~relMask(dn);
    bit [NUM_UNITS-1:0] eu = mUnit & ~dn;
    if (!v)                 begin tag = "R10"; return 0; end
    if (eu[u])              begin tag = "R5";  return 1; end
    if (er[d])              begin tag = "R4";  return 1; end
    if (er[a] || er[b])     begin tag = "R3";  return 1; end
    if ((mReg[d] || mReg[a] || mReg[b] || mUnit[u]) && dn != '0) tag = "R8";
    else tag = "R6";
    return 0;
  endfunction

  task automatic checkFlags();
    checks++;
    if (regBusy !== mReg || unitBusy !== mUnit) begin
      fails++;
      $display("FAIL %s flags: actual reg=%b unit=%b expected reg=%b unit=%b",
               flagTag, regBusy, unitBusy, mReg, mUnit);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input bit v, input int u, input int d, input int a, input int b,
                      input bit [NUM_UNITS-1:0] dn, input string forceTag);
    string tag;
    bit    es;
    checkFlags();
    issueValid = v; issueUnit = UNIT_W'(u); issueDst = REG_W'(d);
    issueSrcA = REG_W'(a); issueSrcB = REG_W'(b); doneValid = dn;
    #1;
    es = expStall(v, u, d, a, b, dn, tag);
    checks++;
    if (stall !== es) begin
      fails++;
      $display("FAIL %s stall: actual %b expected %b", tag, stall, es);
    end
    @(posedge clk);
    // model: release first, then set
    flagTag = ((dn & ~mUnit) != '0) ? "R9" : (dn != '0 ? "R7" : "R2");
    mReg = mReg & ~relMask(dn);
    mUnit = mUnit & ~dn;
    if (v && !es) begin
      mReg[d] = 1'b1; mUnit[u] = 1'b1; mOwner[u] = d;
    end
    if (forceTag != "") flagTag = forceTag;
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; issueValid = 1'b0; doneValid = '0;
    repeat (3) @(negedge clk);
    mReg = '0; mUnit = '0;
    flagTag = "R1";
    checkFlags();
    rstN = 1'b1;
    @(negedge clk);
    checkFlags();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();

    step(1, 0, 3, 1, 2, 4'b0000, "");   // accepted, R6
    step(1, 1, 5, 3, 2, 4'b0000, "");   // source busy, R3
    step(1, 1, 3, 1, 2, 4'b0000, "");   // destination busy, R4
    step(1, 0, 6, 1, 2, 4'b0000, "");   // unit busy, R5
    step(1, 1, 5, 1, 2, 4'b0000, "");   // independent while in flight, R6
    step(1, 2, 3, 3, 0, 4'b0001, "R8"); // release and reissue of reg 3, R8
    step(0, 0, 0, 0, 0, 4'b1000, "R9"); // pulse from idle unit 3, R9
    step(0, 0, 0, 0, 0, 4'b0000, "");   // nothing offered, R10
    step(1, 1, 7, 7, 7, 4'b0010, "R7"); // unit 1 frees in same cycle
    step(0, 0, 0, 0, 0, 4'b0110, "R7");

    for (int n = 0; n < 4000; n++) begin
      bit [NUM_UNITS-1:0] dn;
      for (int k = 0; k < NUM_UNITS; k++) dn[k] = (($urandom % 6) == 0);
      step(($urandom % 10) < 7, int'($urandom % NUM_UNITS), int'($urandom % NUM_REGS),
           int'($urandom % NUM_REGS), int'($urandom % NUM_REGS), dn, "");
    end

    step(1, 3, 4, 0, 1, 4'b0000, "");
    doReset();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule